// File: doc/BRIEF.md
# Word-Parallel Memory Scan CRC-16 Engine

This block computes a CRC-16 checksum over a leading region of a 32-bit-wide read-only memory without help from the processor. Software writes a control byte that holds a run bit and a region size, and setting the run bit launches the scan. While the scan runs, the engine holds a busy line high, which the surrounding logic uses to stall the processor. The engine drives word addresses upward from zero, one per clock. It folds each returned 32-bit word into a CRC register in a single cycle, using the polynomial x^16 + x^12 + x^5 + 1. Bits enter most-significant first, from bit 31 to bit 0, and no bit order is reflected anywhere.

At completion, the engine copies the checksum into a 16-bit result register, clears the run bit and pulses a done flag for one cycle. The region always starts at word 0. The size field counts blocks of 512 words (2 KB), so a value r covers words 0 through (r+1)*512-1. With the default widths, the largest setting covers 64 KB in 16384 fetch cycles plus one cycle to fill the read pipeline.

The controller has three states. IDLE waits for a start write. PRIME issues address 0 while the memory's one-cycle read latency elapses. RUN folds one word per cycle while the next address is already in flight. The transitions are: start (IDLE to PRIME on a control write with the run bit set), fill (PRIME to RUN, unconditional), advance (RUN to RUN while the word being folded is not the last) and finish (RUN to IDLE when the last word is folded).

Top module: `crc_scan_engine`

## Requirements
- R1: After reset, ctl_rdata is 0x00, res_rdata is 0x0000, and busy and done are 0.
- R2: ctl_rdata bit 7 is the run bit, bits 4:0 are the region size and bits 6:5 read 0. A control write while idle stores both fields. If bit 7 of the write is 1, busy is high from the next cycle.
- R3: During a scan, mem_addr starts at 0 and rises by exactly one per cycle up to (size+1)*512-1, then holds there.
- R4: mem_rdata is taken one cycle after its address. A scan of N words keeps busy high for exactly N+1 cycles, with no gap between words.
- R5: The result is the CRC with polynomial 0x1021, seed 0x0000 and no final XOR. Each word is shifted in from bit 31 down to bit 0. For general data it differs from the LSB-first reflected CRC of the same words.
- R6: On the cycle busy falls, res_rdata takes the new result, the run bit reads 0 and done is 1. done is high for that single cycle only.
- R7: Control writes made while busy is high change neither the run bit nor the size field, and do not alter the scan or its result.
- R8: A control write while idle with bit 7 at 0 updates only the size field. It starts no scan and leaves res_rdata unchanged.
- R9: Every scan restarts from seed 0, so repeating a scan over identical data gives an identical result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit 7 run, bits 4:0 size |
| ctl_rdata | output | 8 | Control register read value |
| res_rdata | output | 16 | Result register read value |
| mem_addr | output | 14 | Word address to the memory |
| mem_rdata | input | 32 | Memory read data, one cycle after the address |
| busy | output | 1 | Scan in progress; stalls the processor |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume a memory that returns data exactly one clock after the address. They also assume that nothing outside the block changes the control register during a scan: the write port is the only path, and R7 makes it inert while busy. The bench's memory model is a single registered lookup keyed on mem_addr, so the latency always matches. Its data pattern changes only on the idle cycle before a start write. The bench deliberately issues a write during one scan to exercise the blocking, and every other write falls in idle windows.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } scan_state_t;

    localparam logic [15:0] CRC_POLY = 16'h1021;

    // Folds a 32-bit word into the CRC, bit 31 first.
    function automatic logic [15:0] crc16_fold32(input logic [15:0] crc_in,
                                                 input logic [31:0] word);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 31; i >= 0; i--) begin
            fb = c[15] ^ word[i];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_scan_ctrl.sv
module crc_scan_ctrl
    import crc_scan_pkg::*;
#(
    parameter int RANGE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic [7:0]         ctl_wdata,
    input  logic               rd_last,
    output logic [RANGE_W-1:0] range_q,
    output logic               run_q,
    output logic               seed_clr,
    output logic               issue_en,
    output logic               fold_en,
    output logic               finish,
    output logic               busy,
    output logic               done
);

    scan_state_t state_q, state_d;
    logic        start_req;
    logic        done_q;

    assign start_req = ctl_we && ctl_wdata[7] && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req) state_d = ST_PRIME;
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   if (rd_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        seed_clr = 1'b0;
        issue_en = 1'b0;
        fold_en  = 1'b0;
        finish   = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE:  seed_clr = start_req;
            ST_PRIME: begin
                issue_en = 1'b1;
                busy     = 1'b1;
            end
            ST_RUN: begin
                issue_en = 1'b1;
                fold_en  = 1'b1;
                finish   = rd_last;
                busy     = 1'b1;
            end
            default: ;
        endcase
    end

    // control register: writable only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            range_q <= '0;
        end else if (state_q == ST_IDLE && ctl_we) begin
            run_q   <= ctl_wdata[7];
            range_q <= ctl_wdata[RANGE_W-1:0];
        end else if (finish) begin
            run_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    assign done = done_q;

endmodule

// File: rtl/crc_scan_addr.sv
module crc_scan_addr #(
    parameter int RANGE_W   = 5,
    parameter int STEP_LOG2 = 9,
    localparam int ADDR_W   = RANGE_W + STEP_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_clr,
    input  logic               issue_en,
    input  logic [RANGE_W-1:0] range_q,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               rd_last
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] last_addr;
    logic              last_q;

    assign last_addr = {range_q, {STEP_LOG2{1'b1}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            last_q <= 1'b0;
        end else if (seed_clr) begin
            addr_q <= '0;
            last_q <= 1'b0;
        end else if (issue_en) begin
            // flag travels with the word returned next cycle
            last_q <= (addr_q == last_addr);
            if (addr_q != last_addr) addr_q <= addr_q + 1'b1;
        end
    end

    assign mem_addr = addr_q;
    assign rd_last  = last_q;

endmodule

// File: rtl/crc_scan_crc.sv
module crc_scan_crc
    import crc_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed_clr,
    input  logic        fold_en,
    input  logic        finish,
    input  logic [31:0] word,
    output logic [15:0] result
);

    logic [15:0] crc_q;
    logic [15:0] crc_next;
    logic [15:0] res_q;

    assign crc_next = crc16_fold32(crc_q, word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       crc_q <= 16'h0000;
        else if (seed_clr) crc_q <= 16'h0000;
        else if (fold_en)  crc_q <= crc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      res_q <= 16'h0000;
        else if (finish) res_q <= crc_next;
    end

    assign result = res_q;

endmodule

// File: rtl/crc_scan_engine.sv
module crc_scan_engine #(
    parameter int RANGE_W   = 5,
    parameter int STEP_LOG2 = 9,
    localparam int ADDR_W   = RANGE_W + STEP_LOG2,
    localparam int PAD_W    = 7 - RANGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    output logic [15:0]       res_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              done
);

    logic [RANGE_W-1:0] range_q;
    logic               run_q;
    logic               seed_clr;
    logic               issue_en;
    logic               fold_en;
    logic               finish;
    logic               rd_last;

    crc_scan_ctrl #(.RANGE_W(RANGE_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .ctl_wdata(ctl_wdata),
        .rd_last  (rd_last),
        .range_q  (range_q),
        .run_q    (run_q),
        .seed_clr (seed_clr),
        .issue_en (issue_en),
        .fold_en  (fold_en),
        .finish   (finish),
        .busy     (busy),
        .done     (done)
    );

    crc_scan_addr #(.RANGE_W(RANGE_W), .STEP_LOG2(STEP_LOG2)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_clr(seed_clr),
        .issue_en(issue_en),
        .range_q (range_q),
        .mem_addr(mem_addr),
        .rd_last (rd_last)
    );

    crc_scan_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_clr(seed_clr),
        .fold_en (fold_en),
        .finish  (finish),
        .word    (mem_rdata),
        .result  (res_rdata)
    );

    assign ctl_rdata = {run_q, {PAD_W{1'b0}}, range_q};

endmodule

// File: rtl/crc_scan_chk.sv
module crc_scan_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        ctl_rdata,
    input logic [15:0]       res_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done
);

    AST_ADDR_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_addr == '0);  // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (mem_addr == $past(mem_addr) || (mem_addr - $past(mem_addr)) == ADDR_W'(1)));  // R3

    AST_RUN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ctl_rdata[7]);  // R2

    AST_RANGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ctl_rdata[6:0] == $past(ctl_rdata[6:0]));  // R7

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && !ctl_rdata[7]));  // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6

    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(res_rdata));  // R8

endmodule

bind crc_scan_engine crc_scan_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_rdata(ctl_rdata),
    .res_rdata(res_rdata),
    .mem_addr (mem_addr),
    .busy     (busy),
    .done     (done)
);

// File: tb/sim_crc_scan_engine.sv
module sim_crc_scan_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [7:0]  ctl_rdata;
    logic [15:0] res_rdata;
    logic [13:0] mem_addr;
    logic [31:0] mem_rdata = 32'h0;
    logic        busy;
    logic        done;

    int total = 0;
    int bad   = 0;
    logic [2:0] cur_mode = 3'd0;

    always #4 clk = ~clk;

    crc_scan_engine u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .res_rdata(res_rdata), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .busy(busy), .done(done)
    );

    function automatic logic [31:0] pat(input logic [2:0] mode, input logic [13:0] a);
        logic [31:0] x;
        x = {18'h0, a};
        case (mode)
            3'd0:    return (x * 32'h9E3779B1) ^ 32'h5A5A0000;
            3'd1:    return 32'h0000_0000;
            3'd2:    return {~x[15:0], x[15:0]};
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // memory model: one cycle read latency
    always @(posedge clk) mem_rdata <= pat(cur_mode, mem_addr);

    // augmented-message remainder, bit 31 first
    function automatic logic [15:0] model_crc(input logic [2:0] mode, input int nw);
        logic [15:0] r;
        logic [31:0] d;
        logic        top;
        r = 16'h0;
        for (int w = 0; w < nw; w++) begin
            d = pat(mode, w[13:0]);
            for (int i = 31; i >= 0; i--) begin
                top = r[15];
                r = {r[14:0], d[i]};
                if (top) r = r ^ 16'h1021;
            end
        end
        for (int i = 0; i < 16; i++) begin
            top = r[15];
            r = {r[14:0], 1'b0};
            if (top) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    function automatic logic [15:0] model_reflected(input logic [2:0] mode, input int nw);
        logic [15:0] r;
        logic [31:0] d;
        logic        fb;
        r = 16'h0;
        for (int w = 0; w < nw; w++) begin
            d = pat(mode, w[13:0]);
            for (int i = 0; i < 32; i++) begin
                fb = r[0] ^ d[i];
                r = r >> 1;
                if (fb) r = r ^ 16'h8408;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // runs one scan; optional write attempt during busy
    task automatic run_scan(input logic [4:0] rng, input logic [2:0] mode, input bit inject,
                            output int cyc, output int addr_err, output logic [13:0] last_a,
                            output logic done_seen, output logic done_after);
        logic [13:0] prev;
        @(negedge clk);
        cur_mode  = mode;
        ctl_we    = 1'b1;
        ctl_wdata = {3'b100, rng};
        @(negedge clk);
        ctl_we   = 1'b0;
        cyc      = 0;
        addr_err = 0;
        prev     = 14'h0;
        while (busy && cyc < 40000) begin
            if (cyc == 0) begin
                if (mem_addr !== 14'h0) addr_err++;
            end else if (mem_addr !== prev && mem_addr !== prev + 14'd1) begin
                addr_err++;
            end
            prev = mem_addr;
            if (inject && cyc == 100) begin
                ctl_we    = 1'b1;
                ctl_wdata = 8'h87;
            end else begin
                ctl_we = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        ctl_we     = 1'b0;
        last_a     = prev;
        done_seen  = done;
        @(negedge clk);
        done_after = done;
    endtask

    // {mode[2:0], range[4:0]}
    localparam logic [7:0] VEC [7] = '{
        {3'd0, 5'd0}, {3'd1, 5'd0}, {3'd3, 5'd1}, {3'd2, 5'd3},
        {3'd0, 5'd2}, {3'd0, 5'd0}, {3'd2, 5'd31}
    };

    initial begin
        int cyc, aerr;
        logic [13:0] la;
        logic ds, da;
        logic [15:0] first_res, keep;
        int nw;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 ctl", ctl_rdata, 8'h00);
        check("R1 res", res_rdata, 16'h0000);
        check("R1 busy", busy, 1'b0);
        check("R1 done", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 7; v++) begin
            nw = (int'(VEC[v][4:0]) + 1) * 512;
            run_scan(VEC[v][4:0], VEC[v][7:5], 1'b0, cyc, aerr, la, ds, da);
            check("R5 result", res_rdata, model_crc(VEC[v][7:5], nw));
            check("R4 busy cycles", cyc, nw + 1);
            check("R3 addr sequence", aerr, 0);
            check("R3 last addr", la, nw - 1);
            check("R6 done pulse", {ds, da}, 2'b10);
            check("R6 run cleared", ctl_rdata, {3'b000, VEC[v][4:0]});
            if (v == 0) first_res = res_rdata;
            if (v == 5) check("R9 repeat same", res_rdata, first_res);
        end

        // R5 differs from reflected order
        total++;
        if (first_res == model_reflected(3'd0, 512)) begin
            bad++;
            $display("FAIL R5 reflected actual=%h expected!=%h", first_res, model_reflected(3'd0, 512));
        end

        // R8 write with run bit clear
        keep = res_rdata;
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 8'h06;
        @(negedge clk);
        ctl_we = 1'b0;
        repeat (4) begin
            check("R8 no busy", busy, 1'b0);
            @(negedge clk);
        end
        check("R8 range only", ctl_rdata, 8'h06);
        check("R8 result kept", res_rdata, keep);

        // R7 write during busy ignored
        run_scan(5'd1, 3'd0, 1'b1, cyc, aerr, la, ds, da);
        check("R7 ctl unchanged", ctl_rdata, 8'h01);
        check("R7 result", res_rdata, model_crc(3'd0, 1024));
        check("R7 cycles", cyc, 1025);
        check("R7 last addr", la, 14'd1023);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule